// File: doc/BRIEF.md
# Four-Wide Register Renamer

This block turns up to four decoded instructions per cycle from logical register names into physical register names. Each instruction slot brings two logical source numbers and an optional logical destination, drawn from 32 logical registers. These are mapped onto 64 physical registers. The block keeps three pieces of state:

- a map table from each logical register to its current physical register;
- a bitmap of free physical registers;
- a busy bitmap that records which physical registers still wait for a result.

For each slot the block reports:

- the physical number of both sources and a ready bit for each;
- the freshly allocated physical destination;
- the physical register the destination pointed at before, which a later commit hands back.

Dependencies inside one group are found by comparing logical numbers across the slots. A later slot that reads a register written by an earlier slot in the same group receives that slot's new physical register. It sees that source as not ready.

Two writeback ports clear busy bits as results are produced. Two commit ports return retired previous mappings to the free bitmap. When the free bitmap cannot cover every destination in the group, the whole group waits and no state moves.

Top module: `reg_renamer`

## Requirements
- R1: When `grp_valid` is high and the number of free physical registers is at least the number of destinations the group needs, `ren_fire` is high in that same cycle and `ren_stall` is low.
- R2: A slot needs a destination when `slot_vld`, `slot_wr` are both high and `ldst` is not 0. Such slots receive physical registers that were free, distinct from each other. They are handed out in slot order, lowest free physical number first. On fire the map entry of the destination is updated.
- R3: `pold` of a slot that needs a destination is the latest earlier same-group slot's new register for the same logical destination. Without such a slot it is the map table entry at the start of the cycle.
- R4: A source equal to the logical destination of an earlier needing slot in the group takes the physical register of the latest such slot, and its ready bit is 0.
- R5: Otherwise a source takes the map table entry, and its ready bit is 1 exactly when that physical register is not busy. A writeback clears busy starting with the next cycle, not in the cycle it is presented.
- R6: A physical register allocated on fire is busy from the next cycle until written back.
- R7: When several slots in a fired group write the same logical register, the map entry afterwards holds the last of them.
- R8: When `grp_valid` is high and free registers are fewer than needed, `ren_fire` is 0, `ren_stall` is 1, and the map, free and busy state stay as they were.
- R9: Logical register 0 always reads as physical 0 with ready 1. A destination of 0 allocates nothing and reports `pdst` and `pold` as 0. Writebacks and commits naming physical 0 are ignored.
- R10: After reset, logical register k maps to physical k and is ready, and physical registers 32 to 63 are free.
- R11: A committed physical register becomes allocatable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A rename group is presented |
| slot_vld | input | 4 | Per-slot instruction valid |
| slot_wr | input | 4 | Per-slot destination present |
| lsrc_a | input | 4x5 | Logical first source per slot |
| lsrc_b | input | 4x5 | Logical second source per slot |
| ldst | input | 4x5 | Logical destination per slot |
| ren_fire | output | 1 | Group renamed this cycle |
| ren_stall | output | 1 | Group held for lack of free registers |
| psrc_a | output | 4x6 | Physical first source per slot |
| psrc_b | output | 4x6 | Physical second source per slot |
| pdst | output | 4x6 | New physical destination (valid on fire) |
| pold | output | 4x6 | Previous physical destination (valid on fire) |
| rdy_a | output | 4 | First source ready |
| rdy_b | output | 4 | Second source ready |
| wb_vld | input | 2 | Writeback port valid |
| wb_preg | input | 2x6 | Physical register written back |
| cm_vld | input | 2 | Commit port valid |
| cm_preg | input | 2x6 | Physical register returned to the free bitmap |

## Verification
The bench aims at groups in which one logical register is written twice and read in between. A renamer that scans the group in the wrong direction would hand a reader the wrong producer, or leave the older writer in the map.

It drains the free bitmap to the exact point where a group of four no longer fits. A design with an off-by-one in the count would either hand out a register twice or stall a group that fits.

Writebacks and reads of the same register fall in one cycle. A busy table with an unintended bypass would report ready one cycle early. Commits followed at once by allocation show whether a returned register is picked lowest-first on the next cycle.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
  localparam int RN_SLOTS     = 4;
  localparam int RN_LOG_REGS  = 32;
  localparam int RN_PHYS_REGS = 64;
  localparam int RN_MAXV      = 256;

  // number of set bits in a vector (zero-extended to RN_MAXV)
  function automatic int unsigned ones(input logic [RN_MAXV-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < RN_MAXV; i++) n += int'(v[i]);
    return n;
  endfunction

  // number of set bits strictly below position k
  function automatic int unsigned rank_below(input logic [RN_MAXV-1:0] v, input int unsigned k);
    int unsigned n;
    n = 0;
    for (int i = 0; i < RN_MAXV; i++) if (i < int'(k)) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/rn_free_list.sv
`timescale 1ns/1ps
module rn_free_list #(
  parameter int NPHYS = 64,
  parameter int NLOG  = 32,
  parameter int W     = 4,
  parameter int NCM   = 2,
  localparam int PW = $clog2(NPHYS),
  localparam int CW = $clog2(W + 1),
  localparam int FW = $clog2(NPHYS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [CW-1:0]            take_n,
  input  logic [NCM-1:0]           cm_vld,
  input  logic [NCM-1:0][PW-1:0]   cm_preg,
  output logic [W-1:0][PW-1:0]     pick,
  output logic [FW-1:0]            free_cnt,
  output logic [NPHYS-1:0]         free_vec
);
  import rn_pkg::*;

  logic [NPHYS-1:0] free_q, free_d;
  logic [NPHYS-1:0] rem;

  // W lowest free registers, in ascending order
  always_comb begin
    rem = free_q;
    for (int k = 0; k < W; k++) begin
      pick[k] = '0;
      for (int p = NPHYS - 1; p >= 0; p--)
        if (rem[p]) pick[k] = PW'(p);
      rem[pick[k]] = 1'b0;
    end
  end

  assign free_cnt = FW'(ones(RN_MAXV'(free_q)));
  assign free_vec = free_q;

  always_comb begin
    free_d = free_q;
    if (take)
      for (int k = 0; k < W; k++)
        if (k < int'(take_n)) free_d[pick[k]] = 1'b0;
    for (int c = 0; c < NCM; c++)
      if (cm_vld[c] && cm_preg[c] != '0) free_d[cm_preg[c]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPHYS; p++) free_q[p] <= (p >= NLOG);
    end else begin
      free_q <= free_d;
    end
  end
endmodule

// File: rtl/rn_busy_table.sv
`timescale 1ns/1ps
module rn_busy_table #(
  parameter int NPHYS = 64,
  parameter int W     = 4,
  parameter int NWB   = 2,
  localparam int PW  = $clog2(NPHYS),
  localparam int NRD = 2 * W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0][PW-1:0] rd_preg,
  output logic [NRD-1:0]         rd_busy,
  input  logic [W-1:0]           set_en,
  input  logic [W-1:0][PW-1:0]   set_preg,
  input  logic [NWB-1:0]         wb_vld,
  input  logic [NWB-1:0][PW-1:0] wb_preg,
  output logic [NPHYS-1:0]       busy_vec
);
  logic [NPHYS-1:0] busy_q, busy_d;

  // lookups see the table as it stood at the start of the cycle
  always_comb
    for (int r = 0; r < NRD; r++) rd_busy[r] = busy_q[rd_preg[r]];

  always_comb begin
    busy_d = busy_q;
    for (int c = 0; c < NWB; c++)
      if (wb_vld[c] && wb_preg[c] != '0) busy_d[wb_preg[c]] = 1'b0;
    for (int s = 0; s < W; s++)
      if (set_en[s]) busy_d[set_preg[s]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_d;
  end

  assign busy_vec = busy_q;
endmodule

// File: rtl/rn_map_table.sv
`timescale 1ns/1ps
module rn_map_table #(
  parameter int W     = 4,
  parameter int NLOG  = 32,
  parameter int NPHYS = 64,
  localparam int LW = $clog2(NLOG),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [W-1:0]         want,
  input  logic [W-1:0][LW-1:0] lsrc_a,
  input  logic [W-1:0][LW-1:0] lsrc_b,
  input  logic [W-1:0][LW-1:0] ldst,
  input  logic [W-1:0][PW-1:0] new_p,
  output logic [W-1:0][PW-1:0] psrc_a,
  output logic [W-1:0][PW-1:0] psrc_b,
  output logic [W-1:0]         byp_a,
  output logic [W-1:0]         byp_b,
  output logic [W-1:0][PW-1:0] pold_o
);
  logic [NLOG-1:0][PW-1:0] map_q, map_d;

  // lookup with in-group override; ascending scan so the latest writer wins
  always_comb begin
    for (int i = 0; i < W; i++) begin
      psrc_a[i] = map_q[lsrc_a[i]];
      psrc_b[i] = map_q[lsrc_b[i]];
      byp_a[i]  = 1'b0;
      byp_b[i]  = 1'b0;
      pold_o[i] = want[i] ? map_q[ldst[i]] : '0;
      for (int j = 0; j < W; j++) begin
        if (j < i && want[j]) begin
          if (ldst[j] == lsrc_a[i]) begin psrc_a[i] = new_p[j]; byp_a[i] = 1'b1; end
          if (ldst[j] == lsrc_b[i]) begin psrc_b[i] = new_p[j]; byp_b[i] = 1'b1; end
          if (want[i] && ldst[j] == ldst[i]) pold_o[i] = new_p[j];
        end
      end
    end
  end

  always_comb begin
    map_d = map_q;
    if (commit)
      for (int i = 0; i < W; i++)
        if (want[i]) map_d[ldst[i]] = new_p[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NLOG; l++) map_q[l] <= PW'(l);
    end else begin
      map_q <= map_d;
    end
  end
endmodule

// File: rtl/reg_renamer.sv
`timescale 1ns/1ps
module reg_renamer #(
  parameter int W     = rn_pkg::RN_SLOTS,
  parameter int NLOG  = rn_pkg::RN_LOG_REGS,
  parameter int NPHYS = rn_pkg::RN_PHYS_REGS,
  parameter int NWB   = 2,
  parameter int NCM   = 2,
  localparam int LW = $clog2(NLOG),
  localparam int PW = $clog2(NPHYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   grp_valid,
  input  logic [W-1:0]           slot_vld,
  input  logic [W-1:0]           slot_wr,
  input  logic [W-1:0][LW-1:0]   lsrc_a,
  input  logic [W-1:0][LW-1:0]   lsrc_b,
  input  logic [W-1:0][LW-1:0]   ldst,
  output logic                   ren_fire,
  output logic                   ren_stall,
  output logic [W-1:0][PW-1:0]   psrc_a,
  output logic [W-1:0][PW-1:0]   psrc_b,
  output logic [W-1:0][PW-1:0]   pdst,
  output logic [W-1:0][PW-1:0]   pold,
  output logic [W-1:0]           rdy_a,
  output logic [W-1:0]           rdy_b,
  input  logic [NWB-1:0]         wb_vld,
  input  logic [NWB-1:0][PW-1:0] wb_preg,
  input  logic [NCM-1:0]         cm_vld,
  input  logic [NCM-1:0][PW-1:0] cm_preg
);
  import rn_pkg::*;

  localparam int CW = $clog2(W + 1);
  localparam int FW = $clog2(NPHYS + 1);

  // named internal events, also watched by the checker
  logic [W-1:0]          wants;
  logic [CW-1:0]         grp_need;
  logic [FW-1:0]         free_cnt;
  logic [NPHYS-1:0]      free_vec;
  logic [NPHYS-1:0]      busy_vec;
  logic [W-1:0][PW-1:0]  pick;
  logic [W-1:0][PW-1:0]  new_p;
  logic [W-1:0][PW-1:0]  pold_raw;
  logic [W-1:0]          byp_a, byp_b;
  logic [2*W-1:0][PW-1:0] rd_preg;
  logic [2*W-1:0]        rd_busy;
  logic                  room;

  always_comb
    for (int i = 0; i < W; i++)
      wants[i] = slot_vld[i] & slot_wr[i] & (ldst[i] != '0);

  assign grp_need = CW'(ones(RN_MAXV'(wants)));
  assign room     = FW'(grp_need) <= free_cnt;
  assign ren_fire  = grp_valid & room;
  assign ren_stall = grp_valid & ~room;

  // slot k takes the pick whose index equals the count of needing slots before it
  always_comb
    for (int i = 0; i < W; i++)
      new_p[i] = pick[rank_below(RN_MAXV'(wants), i) % W];

  rn_free_list #(.NPHYS(NPHYS), .NLOG(NLOG), .W(W), .NCM(NCM)) u_free (
    .clk(clk), .rst_n(rst_n),
    .take(ren_fire), .take_n(grp_need),
    .cm_vld(cm_vld), .cm_preg(cm_preg),
    .pick(pick), .free_cnt(free_cnt), .free_vec(free_vec)
  );

  rn_map_table #(.W(W), .NLOG(NLOG), .NPHYS(NPHYS)) u_map (
    .clk(clk), .rst_n(rst_n), .commit(ren_fire), .want(wants),
    .lsrc_a(lsrc_a), .lsrc_b(lsrc_b), .ldst(ldst), .new_p(new_p),
    .psrc_a(psrc_a), .psrc_b(psrc_b), .byp_a(byp_a), .byp_b(byp_b),
    .pold_o(pold_raw)
  );

  always_comb
    for (int i = 0; i < W; i++) begin
      rd_preg[i]     = psrc_a[i];
      rd_preg[W + i] = psrc_b[i];
    end

  rn_busy_table #(.NPHYS(NPHYS), .W(W), .NWB(NWB)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .rd_preg(rd_preg), .rd_busy(rd_busy),
    .set_en(wants & {W{ren_fire}}), .set_preg(new_p),
    .wb_vld(wb_vld), .wb_preg(wb_preg),
    .busy_vec(busy_vec)
  );

  generate
    for (genvar g = 0; g < W; g++) begin : g_slot
      assign rdy_a[g] = ~byp_a[g] & ~rd_busy[g];
      assign rdy_b[g] = ~byp_b[g] & ~rd_busy[W + g];
      assign pdst[g]  = wants[g] ? new_p[g] : '0;
      assign pold[g]  = pold_raw[g];
    end
  endgenerate
endmodule

// File: rtl/rn_check.sv
`timescale 1ns/1ps
module rn_check #(
  parameter int W = 4,
  parameter int NPHYS = 64,
  parameter int LW = 5,
  parameter int PW = 6,
  parameter int CW = 3,
  parameter int FW = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 grp_valid,
  input logic                 ren_fire,
  input logic [CW-1:0]        grp_need,
  input logic [FW-1:0]        free_cnt,
  input logic [NPHYS-1:0]     free_vec,
  input logic [NPHYS-1:0]     busy_vec,
  input logic [W-1:0]         wants,
  input logic [W-1:0][PW-1:0] pdst,
  input logic [W-1:0][LW-1:0] lsrc_a,
  input logic [W-1:0][PW-1:0] psrc_a,
  input logic [W-1:0]         rdy_a
);
  a_r8_hold_only_when_short: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !ren_fire) |-> (FW'(grp_need) > free_cnt));

  a_r1_fire_when_room: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && FW'(grp_need) <= free_cnt) |-> ren_fire);

  a_r1_fire_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |-> grp_valid);

  a_r9_p0_never_free: assert property (@(posedge clk) disable iff (!rst_n)
    !free_vec[0] && !busy_vec[0]);

  generate
    for (genvar i = 0; i < W; i++) begin : g_a
      a_r2_dst_was_free: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && wants[i]) |-> free_vec[pdst[i]]);
      a_r6_new_dst_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && wants[i]) |=> busy_vec[$past(pdst[i])]);
      a_r2_dst_gone_from_free: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_fire && wants[i]) |=> !free_vec[$past(pdst[i])]);
      a_r9_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
        (lsrc_a[i] == '0) |-> (psrc_a[i] == '0 && rdy_a[i]));
      for (genvar j = i + 1; j < W; j++) begin : g_pair
        a_r2_distinct_dst: assert property (@(posedge clk) disable iff (!rst_n)
          (ren_fire && wants[i] && wants[j]) |-> (pdst[i] != pdst[j]));
      end
    end
  endgenerate
endmodule

bind reg_renamer rn_check #(
  .W(W), .NPHYS(NPHYS), .LW(LW), .PW(PW),
  .CW($clog2(W + 1)), .FW($clog2(NPHYS + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .ren_fire(ren_fire),
  .grp_need(grp_need), .free_cnt(free_cnt), .free_vec(free_vec),
  .busy_vec(busy_vec), .wants(wants), .pdst(pdst),
  .lsrc_a(lsrc_a), .psrc_a(psrc_a), .rdy_a(rdy_a)
);

// File: tb/reg_renamer_bench.sv
`timescale 1ns/1ps
module reg_renamer_bench;
  localparam int W = 4, NL = 32, NP = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic grp_valid;
  logic [3:0] slot_vld, slot_wr, rdy_a, rdy_b;
  logic [3:0][4:0] lsrc_a, lsrc_b, ldst;
  logic ren_fire, ren_stall;
  logic [3:0][5:0] psrc_a, psrc_b, pdst, pold;
  logic [1:0] wb_vld, cm_vld;
  logic [1:0][5:0] wb_preg, cm_preg;

  always #4 clk = ~clk;

  reg_renamer u_reg_renamer (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .slot_vld(slot_vld),
    .slot_wr(slot_wr), .lsrc_a(lsrc_a), .lsrc_b(lsrc_b), .ldst(ldst),
    .ren_fire(ren_fire), .ren_stall(ren_stall), .psrc_a(psrc_a), .psrc_b(psrc_b),
    .pdst(pdst), .pold(pold), .rdy_a(rdy_a), .rdy_b(rdy_b),
    .wb_vld(wb_vld), .wb_preg(wb_preg), .cm_vld(cm_vld), .cm_preg(cm_preg));

  int nchk = 0, nbad = 0;
  bit done = 0;

  // reference state
  int mp[NL];
  bit fr[NP];
  bit bz[NP];
  int pend[$];
  int cq[$];
  // expected outputs of the current cycle
  bit e_fire;
  bit want[W];
  int al[W], e_pa[W], e_pb[W], e_po[W];
  bit e_ra[W], e_rb[W];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    grp_valid = 0; slot_vld = '0; slot_wr = '0;
    lsrc_a = '0; lsrc_b = '0; ldst = '0;
    wb_vld = '0; wb_preg = '0; cm_vld = '0; cm_preg = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int l = 0; l < NL; l++) mp[l] = l;
    for (int p = 0; p < NP; p++) begin fr[p] = (p >= NL); bz[p] = 0; end
    pend.delete(); cq.delete();
  endtask

  // source lookup against the reference: latest earlier writer, else map/busy
  task automatic look(input int i, input int s, output int ps, output bit rd);
    ps = mp[s]; rd = !bz[mp[s]];
    for (int j = 0; j < i; j++)
      if (want[j] && int'(ldst[j]) == s) begin ps = al[j]; rd = 0; end
  endtask

  // called 1 ns after inputs change; compares and advances the reference
  task automatic eval();
    int need, cnt;
    bit tf[NP];
    #1;
    need = 0; cnt = 0;
    for (int p = 0; p < NP; p++) begin tf[p] = fr[p]; cnt += int'(fr[p]); end
    for (int i = 0; i < W; i++) begin
      want[i] = slot_vld[i] && slot_wr[i] && ldst[i] != 0;
      al[i] = 0;
      if (want[i]) begin
        need++;
        for (int p = 0; p < NP; p++) if (tf[p]) begin al[i] = p; tf[p] = 0; break; end
      end
    end
    e_fire = grp_valid && need <= cnt;
    for (int i = 0; i < W; i++) begin
      look(i, int'(lsrc_a[i]), e_pa[i], e_ra[i]);
      look(i, int'(lsrc_b[i]), e_pb[i], e_rb[i]);
      e_po[i] = 0;
      if (want[i]) begin
        e_po[i] = mp[ldst[i]];
        for (int j = 0; j < i; j++) if (want[j] && ldst[j] == ldst[i]) e_po[i] = al[j];
      end
    end
    chk(ren_fire == e_fire, "R1", "fire", int'(ren_fire), int'(e_fire));
    chk(ren_stall == (grp_valid && !e_fire), "R8", "stall", int'(ren_stall), int'(grp_valid && !e_fire));
    for (int i = 0; i < W; i++) begin
      chk(int'(psrc_a[i]) == e_pa[i], "R4", "psrc_a", int'(psrc_a[i]), e_pa[i]);
      chk(int'(psrc_b[i]) == e_pb[i], "R4", "psrc_b", int'(psrc_b[i]), e_pb[i]);
      chk(rdy_a[i] == e_ra[i], "R5", "rdy_a", int'(rdy_a[i]), int'(e_ra[i]));
      chk(rdy_b[i] == e_rb[i], "R5", "rdy_b", int'(rdy_b[i]), int'(e_rb[i]));
      if (e_fire) begin
        chk(int'(pdst[i]) == al[i], "R2", "pdst", int'(pdst[i]), al[i]);
        chk(int'(pold[i]) == e_po[i], "R3", "pold", int'(pold[i]), e_po[i]);
      end
    end
    // advance reference: writebacks clear, allocations set, commits free
    for (int c = 0; c < 2; c++) if (wb_vld[c] && wb_preg[c] != 0) bz[wb_preg[c]] = 0;
    if (e_fire)
      for (int i = 0; i < W; i++) if (want[i]) begin
        mp[ldst[i]] = al[i]; fr[al[i]] = 0; bz[al[i]] = 1;
        pend.push_back(al[i]); cq.push_back(e_po[i]);
      end
    for (int c = 0; c < 2; c++) if (cm_vld[c] && cm_preg[c] != 0) fr[cm_preg[c]] = 1;
  endtask

  function automatic bit is_pend(input int p);
    foreach (pend[k]) if (pend[k] == p) return 1;
    return 0;
  endfunction

  task automatic drop_pend(input int p);
    foreach (pend[k]) if (pend[k] == p) begin pend.delete(k); return; end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin : main
    int p_first, p_second, fires, c0, c1;
    idle_inputs();
    do_reset();

    // R10: identity map, all ready, nothing fires
    @(negedge clk);
    for (int i = 0; i < W; i++) begin lsrc_a[i] = 5'(i * 8 + 3); lsrc_b[i] = 5'(31 - i); end
    eval();
    for (int i = 0; i < W; i++) begin
      chk(int'(psrc_a[i]) == i * 8 + 3 && rdy_a[i], "R10", "reset map a", int'(psrc_a[i]), i * 8 + 3);
      chk(int'(psrc_b[i]) == 31 - i && rdy_b[i], "R10", "reset map b", int'(psrc_b[i]), 31 - i);
    end
    chk(!ren_fire, "R10", "idle fire", int'(ren_fire), 0);

    // in-group chain: r5 written twice, read between and after; slot 3 writes r0
    @(negedge clk);
    idle_inputs(); grp_valid = 1; slot_vld = 4'hF; slot_wr = 4'hF;
    ldst[0] = 5; lsrc_a[0] = 1; lsrc_b[0] = 2;
    ldst[1] = 5; lsrc_a[1] = 5; lsrc_b[1] = 0;
    ldst[2] = 7; lsrc_a[2] = 5; lsrc_b[2] = 3;
    ldst[3] = 0; lsrc_a[3] = 7; lsrc_b[3] = 5;
    eval();
    chk(ren_fire, "R1", "group fires", int'(ren_fire), 1);
    chk(pdst[0] == 32 && pdst[1] == 33 && pdst[2] == 34, "R2", "lowest-first", int'(pdst[2]), 34);
    chk(psrc_a[1] == 32 && !rdy_a[1], "R4", "bypass slot1", int'(psrc_a[1]), 32);
    chk(psrc_a[2] == 33 && !rdy_a[2], "R4", "latest writer", int'(psrc_a[2]), 33);
    chk(pold[0] == 5 && pold[1] == 32, "R3", "pold chain", int'(pold[1]), 32);
    chk(pdst[3] == 0 && pold[3] == 0, "R9", "dst r0", int'(pdst[3]), 0);
    chk(psrc_b[1] == 0 && rdy_b[1], "R9", "src r0", int'(psrc_b[1]), 0);
    p_first = int'(pdst[0]); p_second = int'(pdst[1]);

    // R7/R6: r5 now maps to the later writer and is busy; write it back now
    @(negedge clk);
    idle_inputs(); lsrc_a[0] = 5; wb_vld[0] = 1; wb_preg[0] = 6'(p_second);
    eval();
    drop_pend(p_second);
    chk(int'(psrc_a[0]) == p_second, "R7", "last writer in map", int'(psrc_a[0]), p_second);
    chk(!rdy_a[0], "R6", "busy after alloc, wb not yet visible", int'(rdy_a[0]), 0);
    @(negedge clk);
    idle_inputs(); lsrc_a[0] = 5; wb_vld[0] = 1; wb_preg[0] = 0;
    eval();
    chk(rdy_a[0], "R5", "ready after writeback", int'(rdy_a[0]), 1);
    chk(p_first == 32, "R3", "first alloc", p_first, 32);

    // R8 drain: groups of four until the free bitmap runs short
    do_reset();
    fires = 0;
    for (int g = 0; g < 10; g++) begin
      @(negedge clk);
      idle_inputs(); grp_valid = 1; slot_vld = 4'hF; slot_wr = 4'hF;
      for (int i = 0; i < W; i++) begin
        ldst[i] = 5'(1 + ((g * 4 + i) % 31));
        lsrc_a[i] = 5'($urandom % 32); lsrc_b[i] = 5'($urandom % 32);
      end
      eval();
      if (ren_fire) fires++;
    end
    chk(fires == 8, "R8", "groups before stall", fires, 8);
    chk(ren_stall, "R8", "stall with empty list", int'(ren_stall), 1);

    // R11: two commits, then a two-destination group takes them lowest first
    @(negedge clk);
    idle_inputs();
    c0 = cq.pop_front(); c1 = cq.pop_front();
    cm_vld = 2'b11; cm_preg[0] = 6'(c0); cm_preg[1] = 6'(c1);
    eval();
    @(negedge clk);
    idle_inputs(); grp_valid = 1; slot_vld = 4'h3; slot_wr = 4'h3; ldst[0] = 9; ldst[1] = 10;
    eval();
    chk(ren_fire, "R11", "fires after commit", int'(ren_fire), 1);
    chk(int'(pdst[0]) == (c0 < c1 ? c0 : c1), "R11", "reuse low", int'(pdst[0]), (c0 < c1 ? c0 : c1));
    chk(int'(pdst[1]) == (c0 < c1 ? c1 : c0), "R11", "reuse high", int'(pdst[1]), (c0 < c1 ? c1 : c0));

    // random streams with random writebacks and commits
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      idle_inputs();
      grp_valid = ($urandom % 5) != 0;
      for (int i = 0; i < W; i++) begin
        slot_vld[i] = ($urandom % 6) != 0;
        slot_wr[i]  = ($urandom % 4) != 0;
        lsrc_a[i] = 5'($urandom % 12); lsrc_b[i] = 5'($urandom % 12);
        ldst[i]   = 5'($urandom % 12);
      end
      for (int c = 0; c < 2; c++)
        if (pend.size() > 0 && ($urandom % 2) == 0) begin
          int k;
          k = int'($urandom % pend.size());
          wb_vld[c] = 1; wb_preg[c] = 6'(pend[k]); pend.delete(k);
        end
      for (int c = 0; c < 2; c++)
        if (cq.size() > 0 && !is_pend(cq[0]) && ($urandom % 3) != 0) begin
          cm_vld[c] = 1; cm_preg[c] = 6'(cq.pop_front());
        end
      eval();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule